// File: doc/BRIEF.md
# Ticketed Multi-Port Circular Buffer

This block is a shared item buffer with several producer ports and several consumer ports around one circular array of slots (eight by default, four ports per side by default). It uses no single head or tail pointer. Each side has its own ticket dispenser, built as a bitonic balancing network with a small counter on every output wire. A port that raises valid without holding a ticket takes one from its side's dispenser. The ticket value modulo the slot count selects the slot that port will write or read.

Each slot carries one full flag. A producer whose slot is still occupied keeps its ticket and holds off. A consumer whose slot is still empty does the same. The two sides block only on their own slots, so many ports can transfer in the same cycle. The network is evaluated to quiescence every cycle, so all tickets handed out so far always form an unbroken run.

Top module: `cnb_buffer`

## Requirements
- R1: After synchronous active-low reset, every ready output is low and every slot is empty. Both dispensers restart, so the first producer ticket and the first consumer ticket both select slot 0.
- R2: A port with valid high and no ticket takes a ticket at the next rising edge. Its ready is low in that cycle and can be high at the earliest in the following cycle. Each transfer (valid and ready high at an edge) uses up the ticket. Ready is never high while valid is low.
- R3: When tickets are taken one at a time, they select consecutive slots, modulo the slot count, whichever port takes them. Items handed in one at a time therefore leave in the order they entered.
- R4: When k ports of one side take tickets in the same cycle, they receive the next k slot numbers, each exactly once. With those slots free, all k ports are ready in the following cycle.
- R5: A producer whose slot holds an item keeps ready low and keeps its ticket. Its ready rises in the cycle after that slot is emptied.
- R6: A consumer whose slot is empty keeps ready low and keeps its ticket.
- R7: A producer may write into the slot of a waiting consumer. In that same cycle the consumer is ready and its data output carries the item being written.
- R8: Every item accepted from a producer is delivered to exactly one consumer, with its data unchanged, under any mix of valid patterns on both sides.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| prd_valid | input | NPORT | Producer port wants to hand in an item, one bit per port |
| prd_data | input | NPORT x DATA_W | Item offered on each producer port |
| prd_ready | output | NPORT | Producer item is accepted at this edge |
| cns_valid | input | NPORT | Consumer port wants an item, one bit per port |
| cns_data | output | NPORT x DATA_W | Item offered to each consumer port, meaningful while ready |
| cns_ready | output | NPORT | Consumer item is taken at this edge |

## Verification
Some faults misroute a ticket: a balancer toggling the wrong way, a lane counter stepping wrongly, or a ticket not being restarted. Any of these makes two ports share a slot or skip one. That shows up within a few transfers, either as an item arriving out of order in one-at-a-time traffic or as a port that stays not-ready next to a free slot. A full flag that is wrong shows as a consumer taking stale or missing data, or as a producer that never gets ready. The bench checks every delivered item against the set of items accepted but not yet taken.

// File: rtl/cnb_pkg.sv
// Package for the ticketed buffer. It holds the wiring rule of the bitonic
// balancing network. Assumes the width is a power of two, at least 2.
package cnb_pkg;

    // Number of balancer layers in a bitonic network of width n.
    function automatic int cn_layers(input int n);
        int lg;
        lg = $clog2(n);
        return (lg * (lg + 1)) / 2;
    endfunction

    // Wire that wire i is paired with in balancer layer 'layer'.
    // Stage k starts with a mirror pairing inside blocks of 2^k wires,
    // followed by half-cleaner pairings at shrinking strides.
    function automatic int cn_partner(input int n, input int layer, input int i);
        int lg;
        int cnt;
        lg  = $clog2(n);
        cnt = 0;
        for (int k = 1; k <= lg; k++) begin
            for (int sub = 0; sub < k; sub++) begin
                if (cnt == layer) begin
                    if (sub == 0)
                        return i ^ ((1 << k) - 1);
                    else
                        return i ^ (1 << (k - 1 - sub));
                end
                cnt++;
            end
        end
        return i;
    endfunction

endpackage

// File: rtl/cnb_balancer.sv
// One balancer. Takes up to two tokens per cycle and sends each out with the
// port identity it carries. Two tokens together leave one per output and
// keep the toggle. A lone token leaves on the side the toggle names and
// flips it. A fresh toggle sends the first lone token to the top output.
module cnb_balancer #(
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           a_tok,
    input  logic [IDW-1:0] a_id,
    input  logic           b_tok,
    input  logic [IDW-1:0] b_id,
    output logic           top_tok,
    output logic [IDW-1:0] top_id,
    output logic           bot_tok,
    output logic [IDW-1:0] bot_id
);
    logic           tog_q;
    logic           both;
    logic           lone;
    logic [IDW-1:0] lone_id;

    // Route the tokens of this cycle and their identities.
    always_comb begin
        both    = a_tok & b_tok;
        lone    = a_tok ^ b_tok;
        lone_id = a_tok ? a_id : b_id;
        top_tok = both | (lone & ~tog_q);
        bot_tok = both | (lone & tog_q);
        top_id  = both ? a_id : lone_id;
        bot_id  = both ? b_id : lone_id;
    end

    // Flip the toggle for each lone token.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog_q <= 1'b0;
        else if (lone)
            tog_q <= ~tog_q;
    end

    // R4
    tok_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({a_tok, b_tok}) == $countones({top_tok, bot_tok}));

endmodule

// File: rtl/cnb_count_net.sv
// Bitonic balancing network of width NPORT. Input wire p carries port p.
// The network settles within the cycle. Each output wire names the port
// whose token arrived on it. Assumes NPORT is a power of two, at least 2.
module cnb_count_net #(
    parameter int NPORT = 4,
    localparam int IDW  = $clog2(NPORT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORT-1:0]           in_tok,
    output logic [NPORT-1:0]           out_tok,
    output logic [NPORT-1:0][IDW-1:0]  out_id
);
    localparam int NL = cnb_pkg::cn_layers(NPORT);

    logic [NL:0][NPORT-1:0]           tk;
    logic [NL:0][NPORT-1:0][IDW-1:0]  tid;

    // Feed the first layer: token p enters on wire p tagged with p.
    for (genvar i = 0; i < NPORT; i++) begin : g_in
        assign tk[0][i]  = in_tok[i];
        assign tid[0][i] = IDW'(i);
    end

    // One balancer per wire pair and layer, placed at the lower wire.
    for (genvar l = 0; l < NL; l++) begin : g_layer
        for (genvar i = 0; i < NPORT; i++) begin : g_wire
            localparam int PR = cnb_pkg::cn_partner(NPORT, l, i);
            if (i < PR) begin : g_bal
                cnb_balancer #(.IDW(IDW)) u_bal (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .a_tok   (tk[l][i]),
                    .a_id    (tid[l][i]),
                    .b_tok   (tk[l][PR]),
                    .b_id    (tid[l][PR]),
                    .top_tok (tk[l+1][i]),
                    .top_id  (tid[l+1][i]),
                    .bot_tok (tk[l+1][PR]),
                    .bot_id  (tid[l+1][PR])
                );
            end
        end
    end

    assign out_tok = tk[NL];
    assign out_id  = tid[NL];

endmodule

// File: rtl/cnb_dispenser.sv
// Ticket dispenser for one side. A port with valid and no ticket sends a
// token through the network. A counter on each output lane gives the slot
// number: lane o hands out o, o+NPORT, o+2*NPORT and so on, modulo DEPTH.
// A port keeps its slot until it transfers.
// Assumes DEPTH >= NPORT, both powers of two.
module cnb_dispenser #(
    parameter int NPORT = 4,
    parameter int DEPTH = 8,
    localparam int SW   = $clog2(DEPTH),
    localparam int IDW  = $clog2(NPORT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          req_valid,
    input  logic [NPORT-1:0]          fire,
    output logic [NPORT-1:0]          held,
    output logic [NPORT-1:0][SW-1:0]  slot
);
    localparam logic [SW-1:0] STEP = SW'(NPORT % DEPTH);

    logic [NPORT-1:0]           held_q;
    logic [NPORT-1:0][SW-1:0]   slot_q;
    logic [NPORT-1:0]           want;
    logic [NPORT-1:0]           out_tok;
    logic [NPORT-1:0][IDW-1:0]  out_id;
    logic [NPORT-1:0][SW-1:0]   lane_q;
    logic [NPORT-1:0][SW-1:0]   new_slot;

    // Ports that ask for a ticket this cycle.
    assign want = req_valid & ~held_q;

    cnb_count_net #(.NPORT(NPORT)) u_net (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_tok  (want),
        .out_tok (out_tok),
        .out_id  (out_id)
    );

    // Per-lane slot counters, advancing by the network width per token.
    for (genvar o = 0; o < NPORT; o++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[o] <= SW'(o % DEPTH);
            else if (out_tok[o])
                lane_q[o] <= lane_q[o] + STEP;
        end
    end

    // Return each lane's slot to the port whose token used that lane.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            new_slot[p] = '0;
            for (int o = 0; o < NPORT; o++) begin
                if (out_tok[o] && out_id[o] == IDW'(p))
                    new_slot[p] = lane_q[o];
            end
        end
    end

    // Hold each port's ticket from issue until its transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            slot_q <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (fire[p]) begin
                    held_q[p] <= 1'b0;
                end else if (want[p]) begin
                    held_q[p] <= 1'b1;
                    slot_q[p] <= new_slot[p];
                end
            end
        end
    end

    assign held = held_q;
    assign slot = slot_q;

    // R4
    issue_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_tok) == $countones(want));

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        // R2
        ticket_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(held_q[p]) |-> $past(req_valid[p]));
        for (genvar q = p + 1; q < NPORT; q++) begin : g_pair
            // R4
            ticket_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (want[p] && want[q]) |-> (new_slot[p] != new_slot[q]));
        end
    end

endmodule

// File: rtl/cnb_slot_array.sv
// Slot storage with one full flag per slot. A producer is granted when its
// slot is empty. A consumer is granted when its slot is full, or when a
// producer writes that slot in the same cycle (the write comes first).
// If two ports of a side hold the same slot, the lower index wins.
module cnb_slot_array #(
    parameter int NPORT  = 4,
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int SW    = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             p_req,
    input  logic [NPORT-1:0][SW-1:0]     p_slot,
    input  logic [NPORT-1:0][DATA_W-1:0] p_data,
    input  logic [NPORT-1:0]             c_req,
    input  logic [NPORT-1:0][SW-1:0]     c_slot,
    output logic [NPORT-1:0]             p_gnt,
    output logic [NPORT-1:0]             c_gnt,
    output logic [NPORT-1:0][DATA_W-1:0] c_data
);
    logic [DEPTH-1:0]              full_q;
    logic [DEPTH-1:0][DATA_W-1:0]  mem_q;
    logic [DEPTH-1:0]              wr_hit;
    logic [DEPTH-1:0][DATA_W-1:0]  wr_dat;
    logic [DEPTH-1:0]              rd_hit;

    // Pick at most one writer per empty slot, lowest port first.
    always_comb begin
        wr_hit = '0;
        wr_dat = '0;
        p_gnt  = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (p_req[p] && !full_q[p_slot[p]] && !wr_hit[p_slot[p]]) begin
                p_gnt[p]            = 1'b1;
                wr_hit[p_slot[p]]   = 1'b1;
                wr_dat[p_slot[p]]   = p_data[p];
            end
        end
    end

    // Pick at most one reader per occupied or just-written slot.
    always_comb begin
        rd_hit = '0;
        c_gnt  = '0;
        for (int c = 0; c < NPORT; c++) begin
            c_data[c] = full_q[c_slot[c]] ? mem_q[c_slot[c]] : wr_dat[c_slot[c]];
            if (c_req[c] && (full_q[c_slot[c]] || wr_hit[c_slot[c]]) &&
                !rd_hit[c_slot[c]]) begin
                c_gnt[c]          = 1'b1;
                rd_hit[c_slot[c]] = 1'b1;
            end
        end
    end

    // Update the full flags: a write sets, a read clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full_q <= '0;
        else
            full_q <= (full_q | wr_hit) & ~rd_hit;
    end

    // Store written items.
    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (wr_hit[s])
                mem_q[s] <= wr_dat[s];
        end
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot_chk
        logic [NPORT-1:0] hits;
        for (genvar p = 0; p < NPORT; p++) begin : g_hit
            assign hits[p] = p_gnt[p] && (p_slot[p] == SW'(s));
        end
        // R8
        write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hits));
    end

    for (genvar c = 0; c < NPORT; c++) begin : g_port_chk
        // R6
        take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
            c_gnt[c] |=> !full_q[$past(c_slot[c])]);
        // R5
        put_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
            p_gnt[c] |=> (full_q[$past(p_slot[c])] || $past(rd_hit[p_slot[c]])));
    end

endmodule

// File: rtl/cnb_buffer.sv
// Top of the ticketed circular buffer. It has one ticket dispenser per side
// and a shared slot array. A port requests service only while it holds a
// ticket and its valid is high. Assumes NPORT and DEPTH are powers of two,
// DEPTH >= NPORT >= 2, and that valid stays high until ready.
module cnb_buffer #(
    parameter int NPORT  = 4,
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int SW    = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             prd_valid,
    input  logic [NPORT-1:0][DATA_W-1:0] prd_data,
    output logic [NPORT-1:0]             prd_ready,
    input  logic [NPORT-1:0]             cns_valid,
    output logic [NPORT-1:0][DATA_W-1:0] cns_data,
    output logic [NPORT-1:0]             cns_ready
);
    logic [NPORT-1:0]          p_held;
    logic [NPORT-1:0]          c_held;
    logic [NPORT-1:0][SW-1:0]  p_slot;
    logic [NPORT-1:0][SW-1:0]  c_slot;

    cnb_dispenser #(.NPORT(NPORT), .DEPTH(DEPTH)) u_prd_tkt (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (prd_valid),
        .fire      (prd_valid & prd_ready),
        .held      (p_held),
        .slot      (p_slot)
    );

    cnb_dispenser #(.NPORT(NPORT), .DEPTH(DEPTH)) u_cns_tkt (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (cns_valid),
        .fire      (cns_valid & cns_ready),
        .held      (c_held),
        .slot      (c_slot)
    );

    cnb_slot_array #(.NPORT(NPORT), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .p_req  (prd_valid & p_held),
        .p_slot (p_slot),
        .p_data (prd_data),
        .c_req  (cns_valid & c_held),
        .c_slot (c_slot),
        .p_gnt  (prd_ready),
        .c_gnt  (cns_ready),
        .c_data (cns_data)
    );

    // R2
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prd_ready & ~prd_valid) == '0) && ((cns_ready & ~cns_valid) == '0));

endmodule

// File: tb/tb_cnb_buffer.sv
module tb_cnb_buffer;
    localparam int NP = 4;
    localparam int DW = 16;

    logic                   clk;
    logic                   rst_n;
    logic [NP-1:0]          prd_valid;
    logic [NP-1:0][DW-1:0]  prd_data;
    logic [NP-1:0]          prd_ready;
    logic [NP-1:0]          cns_valid;
    logic [NP-1:0][DW-1:0]  cns_data;
    logic [NP-1:0]          cns_ready;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    bit produced [16384];
    bit consumed [16384];

    cnb_buffer #(.NPORT(NP), .DEPTH(8), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .prd_valid(prd_valid), .prd_data(prd_data), .prd_ready(prd_ready),
        .cns_valid(cns_valid), .cns_data(cns_data), .cns_ready(cns_ready)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after a falling edge.
    task automatic do_put(input int p, input logic [DW-1:0] d, output int waits);
        prd_valid[p] = 1'b1;
        prd_data[p]  = d;
        waits = 0;
        #1;
        while (!prd_ready[p] && waits < 50) begin
            @(negedge clk); #1;
            waits++;
        end
        @(negedge clk);
        prd_valid[p] = 1'b0;
    endtask

    task automatic do_get(input int c, output logic [DW-1:0] d, output int waits);
        cns_valid[c] = 1'b1;
        waits = 0;
        #1;
        while (!cns_ready[c] && waits < 50) begin
            @(negedge clk); #1;
            waits++;
        end
        d = cns_data[c];
        @(negedge clk);
        cns_valid[c] = 1'b0;
    endtask

    initial begin
        int w;
        logic [DW-1:0] d;
        logic [3:0] mask;
        int next_tag;
        int nprod;
        int ncons;
        logic [NP-1:0] p_fire;
        logic [NP-1:0] c_fire;
        logic [NP-1:0][DW-1:0] c_dat;
        bit stop;
        int drain;

        void'($urandom(32'd1234));
        rst_n = 1'b0;
        prd_valid = '0;
        prd_data  = '0;
        cns_valid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(prd_ready == '0 && cns_ready == '0, "R1 ready after reset", {prd_ready, cns_ready}, 0);

        // R6: a consumer with nothing stored waits.
        @(negedge clk);
        cns_valid[0] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #1;
            check(cns_ready[0] == 1'b0, "R6 consumer waits on empty slot", cns_ready[0], 0);
            @(negedge clk);
        end

        // R2 and R7: the write reaches the waiting consumer in the same cycle.
        prd_valid[2] = 1'b1;
        prd_data[2]  = 16'h0011;
        #1;
        check(prd_ready[2] == 1'b0, "R2 no ready in ticket cycle", prd_ready[2], 0);
        @(negedge clk); #1;
        check(prd_ready[2] == 1'b1, "R7 producer ready", prd_ready[2], 1);
        check(cns_ready[0] == 1'b1, "R7 consumer ready same cycle", cns_ready[0], 1);
        check(cns_data[0] == 16'h0011, "R7 bypass data", cns_data[0], 16'h0011);
        @(negedge clk);
        prd_valid[2] = 1'b0;
        cns_valid[0] = 1'b0;

        // R3: one-at-a-time tickets from rotating ports fill every slot.
        for (int k = 0; k < 8; k++) begin
            do_put(k % 4, 16'h0100 + 16'(k), w);
            check(w == 1, "R2 ready one cycle after ticket", w, 1);
        end
        // R5: the ninth item finds its slot occupied.
        prd_valid[1] = 1'b1;
        prd_data[1]  = 16'h0108;
        for (int i = 0; i < 6; i++) begin
            #1;
            check(prd_ready[1] == 1'b0, "R5 producer waits on full slot", prd_ready[1], 0);
            @(negedge clk);
        end
        do_get(0, d, w);
        check(d == 16'h0100, "R3 first in-order item", d, 16'h0100);
        #1;
        check(prd_ready[1] == 1'b1, "R5 producer released after take", prd_ready[1], 1);
        @(negedge clk);
        prd_valid[1] = 1'b0;
        for (int k = 1; k < 9; k++) begin
            do_get(k % 4, d, w);
            check(d == 16'h0100 + 16'(k), "R3 in-order item", d, 16'h0100 + k);
        end

        // R4: four simultaneous tickets per side map to four distinct slots.
        for (int p = 0; p < NP; p++) begin
            prd_valid[p] = 1'b1;
            prd_data[p]  = 16'h0200 + 16'(p);
        end
        #1;
        check(prd_ready == 4'h0, "R2 no ready in ticket cycle", prd_ready, 0);
        @(negedge clk); #1;
        check(prd_ready == 4'hF, "R4 all producers ready", prd_ready, 4'hF);
        @(negedge clk);
        prd_valid = '0;
        cns_valid = 4'hF;
        #1;
        check(cns_ready == 4'h0, "R2 no ready in ticket cycle", cns_ready, 0);
        @(negedge clk); #1;
        check(cns_ready == 4'hF, "R4 all consumers ready", cns_ready, 4'hF);
        mask = '0;
        for (int c = 0; c < NP; c++) begin
            if (cns_data[c] >= 16'h0200 && cns_data[c] <= 16'h0203)
                mask[cns_data[c][1:0]] = 1'b1;
        end
        check(mask == 4'hF, "R4 each item once", mask, 4'hF);
        @(negedge clk);
        cns_valid = '0;

        // R1: reset mid-run drops stored items and restarts both dispensers.
        do_put(3, 16'h0333, w);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(prd_ready == '0 && cns_ready == '0, "R1 ready after second reset", {prd_ready, cns_ready}, 0);
        @(negedge clk);
        do_put(0, 16'h0300, w);
        check(w == 1, "R1 slot empty after reset", w, 1);
        do_get(2, d, w);
        check(d == 16'h0300, "R1 dispensers restart together", d, 16'h0300);

        // R8: random traffic on both sides, scoreboarded by unique tags.
        next_tag = 0;
        nprod = 0;
        ncons = 0;
        p_fire = '0;
        c_fire = '0;
        c_dat  = '0;
        stop = 0;
        drain = 0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                if (p_fire[p]) begin
                    produced[prd_data[p][13:0]] = 1'b1;
                    nprod++;
                    prd_valid[p] = 1'b0;
                end
            end
            for (int c = 0; c < NP; c++) begin
                if (c_fire[c]) begin
                    check(produced[c_dat[c][13:0]] && !consumed[c_dat[c][13:0]],
                          "R8 item delivered once", c_dat[c], c_dat[c]);
                    consumed[c_dat[c][13:0]] = 1'b1;
                    ncons++;
                    cns_valid[c] = 1'b0;
                end
            end
            if (cyc >= 3000)
                stop = 1;
            if (stop && prd_valid == '0 && ncons == nprod)
                break;
            if (stop)
                drain++;
            for (int p = 0; p < NP; p++) begin
                if (!prd_valid[p] && !stop && ($urandom % 2) == 0) begin
                    next_tag++;
                    prd_valid[p] = 1'b1;
                    prd_data[p]  = 16'(next_tag);
                end
            end
            for (int c = 0; c < NP; c++) begin
                if (!cns_valid[c] && ($urandom % 3) != 0)
                    cns_valid[c] = 1'b1;
            end
            #1;
            p_fire = prd_valid & prd_ready;
            c_fire = cns_valid & cns_ready;
            c_dat  = cns_data;
        end
        check(ncons == nprod, "R8 all accepted items delivered", ncons, nprod);
        check(nprod > 1000, "R8 random traffic flowed", nprod, 1000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule